// File: doc/BRIEF.md
# Width-Selectable IQ Sample Packer

This block sits in front of a 16-bit-wide receive FIFO. Each cycle that the source asserts `in_valid` while `in_ready` is high, it takes one complex sample made of a signed I and a signed Q component, each `DW` bits wide. It narrows both components to the width picked by `mode_sel` and packs the results into `DW`-bit output words. Each finished word is presented for one cycle with `out_valid`.

One packing rule covers every width. I goes into a field and Q into the field just above it. An older sample always sits below a newer one. A pair of consecutive output words, read low word first, therefore forms one little-endian 32-bit group. The host can unpack all three widths with the same short loop.

A word that is only partly filled is held inside the block. It is thrown away when the mode changes or on a synchronous reset, and packing then starts again at bit 0.

Top module: `iq_packer`

## Requirements
- R1: After a synchronous reset `out_valid` is low and `in_ready` is high. Any partly filled word or pending Q word is discarded, so the next two 4-bit samples form a fresh word.
- R2: With `mode_sel` = 0 (16-bit), an accepted sample gives the full I component on `out_word` in the next cycle and the full Q component in the cycle after that.
- R3: In 16-bit mode `in_ready` is low for exactly the one cycle after an accepted sample. A sample presented during that cycle is ignored and produces no output.
- R4: With `mode_sel` = 1 (8-bit), every accepted sample gives one word in the next cycle. Bits [7:0] hold I[15:8] and bits [15:8] hold Q[15:8].
- R5: With `mode_sel` = 2 (4-bit), a word comes out one cycle after every second accepted sample. From the LSB it holds I of the older sample in [3:0], Q of the older in [7:4], I of the newer in [11:8] and Q of the newer in [15:12], each being the top four bits of its component.
- R6: Narrowing keeps the upper bits of a component and drops the rest without rounding. For example, I = 16'h7FFF gives 8'h7F and 4'h7.
- R7: A change of `mode_sel` discards a half-filled 4-bit word or a Q word not yet emitted. The first sample taken in the new mode starts at the lowest field.
- R8: `out_valid` is high for one cycle for each completed word. Words leave in the order their fields were taken, and no word appears without an accepted sample behind it.
- R9: `mode_sel` = 3 is treated exactly as the 16-bit mode.
- R10: In 4-bit mode, idle cycles between the two samples of a word leave the held half untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Sample width: 0 = 16-bit, 1 = 8-bit, 2 = 4-bit, 3 = same as 0 |
| in_valid | input | 1 | A sample is offered this cycle |
| in_i | input | DW | In-phase component, signed |
| in_q | input | DW | Quadrature component, signed |
| in_ready | output | 1 | Block can take a sample this cycle |
| out_valid | output | 1 | `out_word` holds a completed word this cycle |
| out_word | output | DW | Packed output word |

## Verification
The hardest case to reach is a mode change that lands exactly in the cycle where a 16-bit Q word is still waiting. To get there, the stimulus moves `mode_sel` in the very cycle after the accepted sample, with the source held idle. It then expects only the I word, followed by correctly packed words in the new mode. Other stimulus abandons a half-filled 4-bit word in two ways, by a mode round-trip and by a reset. It then checks that a stale nibble pair never reaches an output word. A sample offered while `in_ready` is low is also driven on purpose, so the scoreboard can show that it vanishes.

// File: rtl/iq_pack_pkg.sv
package iq_pack_pkg;

    // Width selection codes; the reserved code behaves as full width
    typedef enum logic [1:0] {
        MODE_W16 = 2'd0,
        MODE_W8  = 2'd1,
        MODE_W4  = 2'd2,
        MODE_RSV = 2'd3
    } pack_mode_e;

endpackage

// File: rtl/iq_narrow.sv
// Truncating narrower: passes the full component and its upper half and quarter.
module iq_narrow #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   comp,
    output logic [DW-1:0]   full_o,
    output logic [DW/2-1:0] half_o,
    output logic [DW/4-1:0] qtr_o
);
    localparam int HALF = DW / 2;
    localparam int QTR  = DW / 4;

    always_comb begin
        full_o = comp;
        half_o = comp[DW-1 -: HALF];
        qtr_o  = comp[DW-1 -: QTR];
    end
endmodule

// File: rtl/iq_mode_track.sv
// Remembers the mode of the previous cycle and flags any change.
module iq_mode_track (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    output logic       mode_chg
);
    logic [1:0] mode_d, mode_q;

    always_comb begin
        mode_d   = mode_sel;
        mode_chg = (mode_sel != mode_q);
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= iq_pack_pkg::MODE_W16;
        else     mode_q <= mode_d;
    end
endmodule

// File: rtl/iq_pack_core.sv
// Packing state machine: holds pending Q word and half-filled nibble word.
module iq_pack_core #(
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  iq_pack_pkg::pack_mode_e mode,
    input  logic                   mode_chg,
    input  logic                   in_valid,
    input  logic [DW-1:0]          i_full,
    input  logic [DW-1:0]          q_full,
    input  logic [DW/2-1:0]        i_half,
    input  logic [DW/2-1:0]        q_half,
    input  logic [DW/4-1:0]        i_qtr,
    input  logic [DW/4-1:0]        q_qtr,
    output logic                   in_ready,
    output logic                   out_valid,
    output logic [DW-1:0]          out_word
);
    import iq_pack_pkg::*;

    localparam int HALF = DW / 2;

    typedef struct packed {
        logic            q_pend;
        logic [DW-1:0]   q_hold;
        logic            half_full;
        logic [HALF-1:0] nib_hold;
        logic            out_vld;
        logic [DW-1:0]   out_word;
    } pack_st_t;

    pack_st_t st_d, st_q;
    logic     take;

    always_comb begin
        st_d         = st_q;
        st_d.out_vld = 1'b0;
        take         = in_valid && !st_q.q_pend;

        if (mode_chg) begin
            st_d.q_pend    = 1'b0;
            st_d.half_full = 1'b0;
        end

        if (st_q.q_pend) begin
            if (!mode_chg) begin
                st_d.out_vld  = 1'b1;
                st_d.out_word = st_q.q_hold;
                st_d.q_pend   = 1'b0;
            end
        end else if (take) begin
            case (mode)
                MODE_W8: begin
                    st_d.out_vld  = 1'b1;
                    st_d.out_word = {q_half, i_half};
                end
                MODE_W4: begin
                    if (st_q.half_full && !mode_chg) begin
                        st_d.out_vld   = 1'b1;
                        st_d.out_word  = {q_qtr, i_qtr, st_q.nib_hold};
                        st_d.half_full = 1'b0;
                    end else begin
                        st_d.nib_hold  = {q_qtr, i_qtr};
                        st_d.half_full = 1'b1;
                    end
                end
                default: begin
                    st_d.out_vld  = 1'b1;
                    st_d.out_word = i_full;
                    st_d.q_hold   = q_full;
                    st_d.q_pend   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        in_ready  = !st_q.q_pend;
        out_valid = st_q.out_vld;
        out_word  = st_q.out_word;
    end
endmodule

// File: rtl/iq_packer.sv
module iq_packer #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode_sel,
    input  logic          in_valid,
    input  logic [DW-1:0] in_i,
    input  logic [DW-1:0] in_q,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_word
);
    import iq_pack_pkg::*;

    localparam int HALF = DW / 2;
    localparam int QTR  = DW / 4;

    logic [1:0][DW-1:0]   comp_full;
    logic [1:0][HALF-1:0] comp_half;
    logic [1:0][QTR-1:0]  comp_qtr;
    logic [1:0][DW-1:0]   comp_in;
    logic                 mode_chg;
    pack_mode_e           mode_e;

    assign comp_in[0] = in_i;
    assign comp_in[1] = in_q;
    assign mode_e     = pack_mode_e'(mode_sel);

    for (genvar c = 0; c < 2; c++) begin : g_narrow
        iq_narrow #(.DW(DW)) u_narrow (
            .comp   (comp_in[c]),
            .full_o (comp_full[c]),
            .half_o (comp_half[c]),
            .qtr_o  (comp_qtr[c])
        );
    end

    iq_mode_track u_mode (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .mode_chg (mode_chg)
    );

    iq_pack_core #(.DW(DW)) u_core (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .mode_chg  (mode_chg),
        .in_valid  (in_valid),
        .i_full    (comp_full[0]),
        .q_full    (comp_full[1]),
        .i_half    (comp_half[0]),
        .q_half    (comp_half[1]),
        .i_qtr     (comp_qtr[0]),
        .q_qtr     (comp_qtr[1]),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_word  (out_word)
    );
endmodule

// File: rtl/iq_packer_chk.sv
module iq_packer_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode_sel,
    input logic          in_valid,
    input logic [DW-1:0] in_i,
    input logic [DW-1:0] in_q,
    input logic          in_ready,
    input logic          out_valid,
    input logic [DW-1:0] out_word
);
    logic acc, wide;
    assign acc  = in_valid && in_ready;
    assign wide = (mode_sel == 2'd0) || (mode_sel == 2'd3);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    assert_i_word_R2: assert property (@(posedge clk) disable iff (rst)
        (acc && wide) |=> (out_valid && out_word == $past(in_i)));

    assert_q_word_R2: assert property (@(posedge clk) disable iff (rst)
        (acc && wide) ##1 (mode_sel == $past(mode_sel))
        |=> (out_valid && out_word == $past(in_q, 2)));

    assert_busy_cause_R3: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> $past(acc && wide));

    assert_busy_one_R3: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready);

    assert_byte_word_R4: assert property (@(posedge clk) disable iff (rst)
        (acc && mode_sel == 2'd1)
        |=> (out_valid && out_word == {$past(in_q[DW-1 -: DW/2]), $past(in_i[DW-1 -: DW/2])}));

    assert_word_origin_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(acc) || $past(!in_ready)));
endmodule

bind iq_packer iq_packer_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/iq_packer_bench.sv
module iq_packer_bench;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode_sel = 2'd0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_i = '0;
    logic [DW-1:0] in_q = '0;
    logic          in_ready;
    logic          out_valid;
    logic [DW-1:0] out_word;

    always #5 clk = ~clk;

    iq_packer #(.DW(DW)) u_iq_packer (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .in_ready(in_ready),
        .out_valid(out_valid), .out_word(out_word)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    int       bm_mode = 0;
    bit       bm_half = 1'b0;
    logic [7:0] bm_nib = '0;

    task automatic check(input bit ok, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] w, input string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    // Reference packing model written from the requirements
    task automatic model(input logic [DW-1:0] i, input logic [DW-1:0] q, input string tag);
        case (bm_mode)
            1: push({q[15:8], i[15:8]}, tag);
            2: begin
                if (!bm_half) begin
                    bm_nib  = {q[15:12], i[15:12]};
                    bm_half = 1'b1;
                end else begin
                    push({q[15:12], i[15:12], bm_nib}, tag);
                    bm_half = 1'b0;
                end
            end
            default: begin
                push(i, tag);
                push(q, tag);
            end
        endcase
    endtask

    task automatic send(input logic [DW-1:0] i, input logic [DW-1:0] q, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_i = i;
        in_q = q;
        model(i, q, tag);
        if (bm_mode == 0 || bm_mode == 3) begin
            @(negedge clk);
            in_valid = 1'b0;
            check(in_ready == 1'b0, "R3 ready low after wide sample", {15'd0, in_ready}, '0);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic set_mode(input int m);
        @(negedge clk);
        in_valid = 1'b0;
        mode_sel = 2'(m);
        if (m != bm_mode) bm_half = 1'b0;
        bm_mode = m;
    endtask

    task automatic drain(input string tag);
        idle(4);
        check(exp_q.size() == 0, tag, DW'(exp_q.size()), '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        bm_half = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid low after reset", {15'd0, out_valid}, '0);
        check(in_ready == 1'b1, "R1 ready high after reset", {15'd0, in_ready}, 16'd1);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 word without sample", out_word, '0);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_word == e, t, out_word, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid low at start", {15'd0, out_valid}, '0);
        check(in_ready == 1'b1, "R1 ready high at start", {15'd0, in_ready}, 16'd1);

        // 16-bit mode
        send(16'h1234, 16'hABCD, "R2 wide word");
        send(16'h8001, 16'h7FFF, "R2 wide word");
        drain("R8 wide queue empty");

        // Sample offered while ready is low is dropped
        @(negedge clk);
        in_valid = 1'b1; in_i = 16'h1111; in_q = 16'h2222;
        model(16'h1111, 16'h2222, "R3 word before stall");
        @(negedge clk);
        in_i = 16'h3333; in_q = 16'h4444;
        check(in_ready == 1'b0, "R3 ready low in stall", {15'd0, in_ready}, '0);
        @(negedge clk);
        in_valid = 1'b0;
        drain("R3 stalled sample ignored");

        // Reserved code acts as 16-bit
        set_mode(3);
        send(16'h5A5A, 16'hA5A5, "R9 reserved as wide");
        drain("R9 queue empty");

        // 8-bit mode, back to back
        set_mode(1);
        send(16'h1234, 16'h5678, "R4 byte word");
        send(16'hFF00, 16'h00FF, "R4 byte word");
        send(16'h8000, 16'h7F00, "R4 byte word");
        send(16'h7FFF, 16'h80FF, "R6 byte truncation");
        idle(1);
        drain("R4 queue empty");

        // 4-bit mode, back to back
        set_mode(2);
        send(16'h1000, 16'h2000, "R5 nibble word");
        send(16'h3000, 16'h4000, "R5 nibble word");
        send(16'hA123, 16'hB456, "R5 nibble word");
        send(16'hC789, 16'hDABC, "R5 nibble word");
        send(16'h0FFF, 16'h7FFF, "R6 nibble truncation");
        send(16'h1000, 16'hEFFF, "R6 nibble truncation");
        // idle cycles between halves
        send(16'h6000, 16'h9000, "R10 gap keeps half");
        idle(3);
        send(16'h2000, 16'h5000, "R10 gap keeps half");
        idle(1);
        drain("R5 queue empty");

        // Half word abandoned by mode change
        send(16'hF000, 16'hE000, "R7 stale half");
        set_mode(1);
        send(16'h4321, 16'h8765, "R7 byte after change");
        set_mode(2);
        send(16'h3000, 16'h4000, "R7 fresh nibble word");
        send(16'h5000, 16'h6000, "R7 fresh nibble word");
        idle(1);
        drain("R7 queue empty");

        // Pending Q word abandoned by mode change
        set_mode(0);
        @(negedge clk);
        in_valid = 1'b1; in_i = 16'hC0DE; in_q = 16'hDEAD;
        push(16'hC0DE, "R7 I kept before change");
        @(negedge clk);
        in_valid = 1'b0;
        mode_sel = 2'd1;
        bm_mode = 1;
        bm_half = 1'b0;
        send(16'h2B00, 16'h1A00, "R7 byte after discarded Q");
        idle(1);
        drain("R7 Q word discarded");

        // Reset abandons a half word
        set_mode(2);
        send(16'h9000, 16'h8000, "R1 stale half");
        do_reset();
        send(16'h1000, 16'h2000, "R1 fresh after reset");
        send(16'h3000, 16'h4000, "R1 fresh after reset");
        idle(1);
        drain("R1 queue empty");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule